// File: doc/BRIEF.md
# Context-Configured Hybrid-Granularity Processing Element

This block is one cell of a coarse-grained reconfigurable array. It fetches no instructions. A configuration context word is loaded once over a dedicated port and held in a context register. The fields of that word choose the word operation, where each operand comes from, what the single-bit lane computes, and where the result goes. Once configured, the cell fires whenever a valid token is presented on its input handshake. Operands can come from the four nearest neighbours, from a four-entry local register file, from an immediate, or from the previous result.

Next to the 32-bit word lane sits a 1-bit lane for bit-level and control-flow work. A registered flag is taken from each word result. It is either a zero test or the sign bit, and it steers the select operation of the next firing. A result can be written back into the local register file for short-term reuse. It can also be pushed out as a store request toward shared memory. The request holds until the memory side grants it.

Top module: `pe_hybrid`

## Requirements
- R1: A context word is captured while `cfg_load_i` is high; when the strobe is held several cycles the last word wins. The captured word becomes active in the first cycle the strobe is low, and `in_ready_o` is low while the strobe is high and during that commit cycle, so every accepted token runs under one whole context. After reset the active context is all zeros. Context bit layout from bit 0 upward: op[3:0], srca[6:4], srcb[9:7], ra[11:10], rb[13:12], wr_en[14], st_en[15], wa[17:16], bop[20:18], bsa[22:21], bsb[24:23], flag_sign[25], imm[41:26].
- R2: Operand source codes for srca/srcb: 0 north, 1 east, 2 south, 3 west (neighbour k at `nbr_word_i[32k+:32]`), 4 register file (A reads entry ra, B reads entry rb), 5 sign-extended imm, 6 previous result, 7 zero.
- R3: Word op codes 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SUB (A-B), 5 MUL keeping the low 32 bits of the product, 14 PASS A.
- R4: Shift ops use B[4:0] as the amount: 7 shift left, 8 logical shift right, 9 arithmetic shift right.
- R5: Op 6 counts leading zeros of A and gives 32 for zero; op 11 is absolute value of A, and 0x80000000 comes back unchanged; ops 12 and 13 are signed minimum and maximum.
- R6: Op 10 selects A when the flag register is 1 and B otherwise. The flag is updated at every accepted token: with flag_sign=0 it is 1 when the result is zero, with flag_sign=1 it is the result's bit 31.
- R7: The bit lane takes a = `nbr_bit_i[bsa]`, b = `nbr_bit_i[bsb]`; bop 0 AND, 1 OR, 2 XOR, 3 NOT a, 4 pass a, 5 to 7 give 0.
- R8: When wr_en is set, the result is written to register entry wa. A token accepted in the very next cycle that reads that entry sees the new value.
- R9: `out_valid_o` is high exactly in the cycle after an accepted token, with the result on `out_word_o`, `out_bit_o`, `out_flag_o`; these hold between tokens.
- R10: With st_en set, `st_req_o` rises one cycle after acceptance with the result on `st_data_o` and imm[7:0] on `st_addr_o`. All three stay unchanged until a cycle with `st_gnt_i` high, after which the request drops. `in_ready_o` is low while the request is pending.
- R11: After reset `out_valid_o`, `st_req_o`, `out_word_o` and `out_flag_o` are 0 and `in_ready_o` is 1.
- R12: Op code 15 gives a zero word result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Context load strobe |
| cfg_word_i | input | 42 | Context word |
| in_valid_i | input | 1 | Input token valid |
| in_ready_o | output | 1 | Cell can accept a token |
| nbr_word_i | input | 128 | Neighbour words, N/E/S/W from low to high |
| nbr_bit_i | input | 4 | Neighbour bits, N/E/S/W |
| out_valid_o | output | 1 | Result valid |
| out_word_o | output | 32 | Word lane result |
| out_bit_o | output | 1 | Bit lane result |
| out_flag_o | output | 1 | Flag from the word result |
| st_req_o | output | 1 | Store request to shared memory |
| st_gnt_i | input | 1 | Store grant |
| st_addr_o | output | 8 | Store address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions check the handshake on every cycle. They cover the one-cycle step from acceptance to result-valid, the results holding between tokens, the store request keeping its address and data until granted and dropping after the grant, and no token being accepted during a context load or a pending store. The arithmetic is left to the bench scenarios. That covers each operation's value, the corner values of leading-zero count and absolute value, the flag steering a later select, and the same-entry write-then-read across back-to-back tokens. The bench scenarios also show that a repeated load strobe keeps only its final word.

// File: rtl/pe_cfg_pkg.sv
package pe_cfg_pkg;
  localparam int IMM_W  = 16;
  localparam int RF_AW  = 2;
  localparam int NBR_N  = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_OR = 4'd1, OP_XOR = 4'd2, OP_ADD = 4'd3,
    OP_SUB = 4'd4, OP_MUL = 4'd5, OP_CLZ = 4'd6, OP_SHL = 4'd7,
    OP_SHR = 4'd8, OP_SRA = 4'd9, OP_SEL = 4'd10, OP_ABS = 4'd11,
    OP_MIN = 4'd12, OP_MAX = 4'd13, OP_PASS = 4'd14, OP_NONE = 4'd15
  } word_op_e;

  typedef enum logic [2:0] {
    SRC_N = 3'd0, SRC_E = 3'd1, SRC_S = 3'd2, SRC_W = 3'd3,
    SRC_RF = 3'd4, SRC_IMM = 3'd5, SRC_PREV = 3'd6, SRC_ZERO = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    BOP_AND = 3'd0, BOP_OR = 3'd1, BOP_XOR = 3'd2, BOP_NOT = 3'd3,
    BOP_PASS = 3'd4, BOP_Z5 = 3'd5, BOP_Z6 = 3'd6, BOP_Z7 = 3'd7
  } bit_op_e;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic             flag_sign;
    logic [1:0]       bsb;
    logic [1:0]       bsa;
    bit_op_e          bop;
    logic [RF_AW-1:0] wa;
    logic             st_en;
    logic             wr_en;
    logic [RF_AW-1:0] rb;
    logic [RF_AW-1:0] ra;
    src_e             srcb;
    src_e             srca;
    word_op_e         op;
  } ctx_t;

  localparam int CTX_W = $bits(ctx_t);
endpackage

// File: rtl/pe_ctx_ctrl.sv
module pe_ctx_ctrl
  import pe_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CTX_W-1:0] word_i,
  output logic             busy_o,
  output ctx_t             ctx_o
);
  ctx_t shadow_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      ctx_o    <= '0;
    end else begin
      if (load_i) begin
        shadow_q <= ctx_t'(word_i);
        pend_q   <= 1'b1;
      end else if (pend_q) begin
        ctx_o  <= shadow_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign busy_o = pend_q || load_i;
endmodule

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int DW = 32,
  parameter int AW = 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra0_i,
  input  logic [AW-1:0] ra1_i,
  output logic [DW-1:0] rd0_o,
  output logic [DW-1:0] rd1_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  assign rd0_o = mem[ra0_i];
  assign rd1_o = mem[ra1_i];
endmodule

// File: rtl/pe_word_alu.sv
module pe_word_alu
  import pe_cfg_pkg::*;
#(
  parameter int DW = 32,
  localparam int SHW = $clog2(DW)
) (
  input  word_op_e      op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sel_i,
  output logic [DW-1:0] y_o
);
  logic [SHW-1:0] shamt;
  logic [SHW:0]   lz;
  logic [DW-1:0]  prod;

  assign shamt = b_i[SHW-1:0];
  assign prod  = a_i * b_i;

  always_comb begin
    lz = SHW'(0) + (SHW+1)'(DW);
    for (int i = 0; i < DW; i++) begin
      if (a_i[i]) lz = (SHW+1)'(DW - 1 - i);
    end
  end

  always_comb begin
    case (op_i)
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = prod;
      OP_CLZ:  y_o = DW'(lz);
      OP_SHL:  y_o = a_i << shamt;
      OP_SHR:  y_o = a_i >> shamt;
      OP_SRA:  y_o = $signed(a_i) >>> shamt;
      OP_SEL:  y_o = sel_i ? a_i : b_i;
      OP_ABS:  y_o = a_i[DW-1] ? (~a_i + DW'(1)) : a_i;
      OP_MIN:  y_o = ($signed(a_i) < $signed(b_i)) ? a_i : b_i;
      OP_MAX:  y_o = ($signed(a_i) < $signed(b_i)) ? b_i : a_i;
      OP_PASS: y_o = a_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/pe_bit_alu.sv
module pe_bit_alu
  import pe_cfg_pkg::*;
(
  input  bit_op_e op_i,
  input  logic    a_i,
  input  logic    b_i,
  output logic    y_o
);
  always_comb begin
    case (op_i)
      BOP_AND:  y_o = a_i & b_i;
      BOP_OR:   y_o = a_i | b_i;
      BOP_XOR:  y_o = a_i ^ b_i;
      BOP_NOT:  y_o = ~a_i;
      BOP_PASS: y_o = a_i;
      default:  y_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pe_hybrid.sv
module pe_hybrid
  import pe_cfg_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_load_i,
  input  logic [CTX_W-1:0]     cfg_word_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [NBR_N*DW-1:0]  nbr_word_i,
  input  logic [NBR_N-1:0]     nbr_bit_i,
  output logic                 out_valid_o,
  output logic [DW-1:0]        out_word_o,
  output logic                 out_bit_o,
  output logic                 out_flag_o,
  output logic                 st_req_o,
  input  logic                 st_gnt_i,
  output logic [ADDR_W-1:0]    st_addr_o,
  output logic [DW-1:0]        st_data_o
);
  ctx_t          ctx;
  logic          ctx_busy;
  logic          fire;
  logic [DW-1:0] nbr_w [NBR_N];
  logic [DW-1:0] rf_rd [2];
  logic [DW-1:0] opnd  [2];
  src_e          osel  [2];
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] word_y;
  logic          bit_y;

  for (genvar g = 0; g < NBR_N; g++) begin : g_nbr
    assign nbr_w[g] = nbr_word_i[g*DW +: DW];
  end

  pe_ctx_ctrl u_ctx (
    .clk(clk), .rst(rst), .load_i(cfg_load_i), .word_i(cfg_word_i),
    .busy_o(ctx_busy), .ctx_o(ctx)
  );

  assign in_ready_o = !st_req_o && !ctx_busy;
  assign fire       = in_valid_i && in_ready_o;

  pe_regfile #(.DW(DW), .AW(RF_AW)) u_rf (
    .clk(clk), .we_i(fire && ctx.wr_en), .wa_i(ctx.wa), .wd_i(word_y),
    .ra0_i(ctx.ra), .ra1_i(ctx.rb), .rd0_o(rf_rd[0]), .rd1_o(rf_rd[1])
  );

  assign imm_ext = {{(DW-IMM_W){ctx.imm[IMM_W-1]}}, ctx.imm};
  assign osel[0] = ctx.srca;
  assign osel[1] = ctx.srcb;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      case (osel[k])
        SRC_N:    opnd[k] = nbr_w[0];
        SRC_E:    opnd[k] = nbr_w[1];
        SRC_S:    opnd[k] = nbr_w[2];
        SRC_W:    opnd[k] = nbr_w[3];
        SRC_RF:   opnd[k] = rf_rd[k];
        SRC_IMM:  opnd[k] = imm_ext;
        SRC_PREV: opnd[k] = out_word_o;
        default:  opnd[k] = '0;
      endcase
    end
  end

  pe_word_alu #(.DW(DW)) u_walu (
    .op_i(ctx.op), .a_i(opnd[0]), .b_i(opnd[1]), .sel_i(out_flag_o),
    .y_o(word_y)
  );

  pe_bit_alu u_balu (
    .op_i(ctx.bop), .a_i(nbr_bit_i[ctx.bsa]), .b_i(nbr_bit_i[ctx.bsb]),
    .y_o(bit_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
      out_bit_o   <= 1'b0;
      out_flag_o  <= 1'b0;
      st_req_o    <= 1'b0;
      st_addr_o   <= '0;
      st_data_o   <= '0;
    end else begin
      out_valid_o <= fire;
      if (fire) begin
        out_word_o <= word_y;
        out_bit_o  <= bit_y;
        out_flag_o <= ctx.flag_sign ? word_y[DW-1] : (word_y == '0);
      end
      if (fire && ctx.st_en) begin
        st_req_o  <= 1'b1;
        st_data_o <= word_y;
        st_addr_o <= ctx.imm[ADDR_W-1:0];
      end else if (st_req_o && st_gnt_i) begin
        st_req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pe_hybrid_chk.sv
module pe_hybrid_chk #(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DW-1:0]     out_word_o,
  input logic              st_req_o,
  input logic              st_gnt_i,
  input logic [ADDR_W-1:0] st_addr_o,
  input logic [DW-1:0]     st_data_o
);
  a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);

  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    !(in_valid_i && in_ready_o) |=> $stable(out_word_o));

  a_r10_store_held: assert property (@(posedge clk) disable iff (rst)
    (st_req_o && !st_gnt_i) |=> (st_req_o && $stable(st_data_o) && $stable(st_addr_o)));

  a_r10_store_drops: assert property (@(posedge clk) disable iff (rst)
    (st_req_o && st_gnt_i) |=> !st_req_o);

  a_r10_stall_on_store: assert property (@(posedge clk) disable iff (rst)
    st_req_o |-> !in_ready_o);

  a_r1_stall_on_load: assert property (@(posedge clk) disable iff (rst)
    cfg_load_i |-> !in_ready_o);
endmodule

bind pe_hybrid pe_hybrid_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_load_i(cfg_load_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_word_o(out_word_o),
  .st_req_o(st_req_o), .st_gnt_i(st_gnt_i), .st_addr_o(st_addr_o),
  .st_data_o(st_data_o)
);

// File: tb/pe_hybrid_tb.sv
`timescale 1ns/1ps
module pe_hybrid_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_load_i = 1'b0;
  logic [41:0]  cfg_word_i = '0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [127:0] nbr_word_i = '0;
  logic [3:0]   nbr_bit_i = '0;
  logic         out_valid_o;
  logic [31:0]  out_word_o;
  logic         out_bit_o;
  logic         out_flag_o;
  logic         st_req_o;
  logic         st_gnt_i = 1'b0;
  logic [7:0]   st_addr_o;
  logic [31:0]  st_data_o;

  always #2.5 clk = ~clk;

  pe_hybrid u_dut (.*);

  typedef struct {
    logic [31:0] w;
    logic        b;
    logic        f;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // layout: imm, flag_sign, bsb, bsa, bop, wa, st_en, wr_en, rb, ra, srcb, srca, op
  function automatic logic [41:0] mk(input logic [3:0] op, input logic [2:0] sa, sb,
      input logic [1:0] ra, rb, input logic wen, st, input logic [1:0] wa,
      input logic [2:0] bop, input logic [1:0] bsa, bsb, input logic fs,
      input logic [15:0] imm);
    return {imm, fs, bsb, bsa, bop, wa, st, wen, rb, ra, sb, sa, op};
  endfunction

  function automatic logic [41:0] mkop(input logic [3:0] op, input logic fs,
      input logic [2:0] bop);
    return mk(op, 3'd0, 3'd1, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, bop, 2'd0, 2'd1, fs, 16'h0);
  endfunction

  function automatic logic [127:0] nw(input logic [31:0] n, e, s, w);
    return {w, s, e, n};
  endfunction

  task automatic load_ctx(input logic [41:0] c);
    @(negedge clk);
    cfg_load_i = 1'b1;
    cfg_word_i = c;
    @(negedge clk);
    cfg_load_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue(input logic [127:0] w, input logic [3:0] b,
      input logic [31:0] ew, input logic eb, input logic ef, input string tag);
    exp_t e;
    while (!in_ready_o) @(negedge clk);
    nbr_word_i = w;
    nbr_bit_i  = b;
    in_valid_i = 1'b1;
    e.w = ew; e.b = eb; e.f = ef; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " word"}, out_word_o, e.w);
        check({e.tag, " bit"},  {31'd0, out_bit_o}, {31'd0, e.b});
        check({e.tag, " flag"}, {31'd0, out_flag_o}, {31'd0, e.f});
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {31'd0, out_valid_o}, 32'd0);
    check("R11 st_req", {31'd0, st_req_o}, 32'd0);
    check("R11 in_ready", {31'd0, in_ready_o}, 32'd1);
    check("R11 out_word", out_word_o, 32'd0);
    check("R11 out_flag", {31'd0, out_flag_o}, 32'd0);
    // R1 reset context is all zeros: AND of north with itself, bit AND of bit 0
    issue(nw(32'h1234, 32'hFFFF, 0, 0), 4'b0001, 32'h1234, 1'b1, 1'b0, "R1 reset ctx");

    // R3 logic and arithmetic, R7 bit lane
    load_ctx(mkop(4'd0, 1'b0, 3'd0));
    issue(nw(32'hF0F01234, 32'h0FF0FF00, 0, 0), 4'b0011, 32'h00F01200, 1'b1, 1'b0, "R3 AND / R7 AND");
    load_ctx(mkop(4'd1, 1'b0, 3'd1));
    issue(nw(32'h12000034, 32'h00456700, 0, 0), 4'b0001, 32'h12456734, 1'b1, 1'b0, "R3 OR / R7 OR");
    load_ctx(mkop(4'd2, 1'b1, 3'd2));
    issue(nw(32'hFFFF0000, 32'h0F0F0F0F, 0, 0), 4'b0011, 32'hF0F00F0F, 1'b0, 1'b1, "R3 XOR / R7 XOR / R6 sign");
    load_ctx(mkop(4'd3, 1'b1, 3'd3));
    issue(nw(32'h7FFFFFFF, 32'h1, 0, 0), 4'b0000, 32'h80000000, 1'b1, 1'b1, "R3 ADD / R7 NOT");
    load_ctx(mkop(4'd4, 1'b0, 3'd4));
    issue(nw(32'd5, 32'd7, 0, 0), 4'b0001, 32'hFFFFFFFE, 1'b1, 1'b0, "R3 SUB / R7 PASS");
    load_ctx(mkop(4'd5, 1'b1, 3'd5));
    issue(nw(32'hFFFFFFFF, 32'd2, 0, 0), 4'b0011, 32'hFFFFFFFE, 1'b0, 1'b1, "R3 MUL low / R7 zero code");
    issue(nw(32'h00010001, 32'h00010001, 0, 0), 4'b0011, 32'h00020001, 1'b0, 1'b0, "R3 MUL");

    // R5 leading zeros, absolute value, min and max
    load_ctx(mkop(4'd6, 1'b0, 3'd0));
    issue(nw(32'h0, 0, 0, 0), 4'b0000, 32'd32, 1'b0, 1'b0, "R5 CLZ zero");
    issue(nw(32'h00010000, 0, 0, 0), 4'b0000, 32'd15, 1'b0, 1'b0, "R5 CLZ");
    load_ctx(mkop(4'd11, 1'b1, 3'd0));
    issue(nw(32'h80000000, 0, 0, 0), 4'b0000, 32'h80000000, 1'b0, 1'b1, "R5 ABS min");
    issue(nw(32'hFFFFFFFB, 0, 0, 0), 4'b0000, 32'd5, 1'b0, 1'b0, "R5 ABS");
    load_ctx(mkop(4'd12, 1'b0, 3'd0));
    issue(nw(32'hFFFFFFFF, 32'd1, 0, 0), 4'b0000, 32'hFFFFFFFF, 1'b0, 1'b0, "R5 MIN");
    load_ctx(mkop(4'd13, 1'b0, 3'd0));
    issue(nw(32'hFFFFFFFF, 32'd1, 0, 0), 4'b0000, 32'd1, 1'b0, 1'b0, "R5 MAX");

    // R4 shifts with amount from low five bits
    load_ctx(mkop(4'd7, 1'b0, 3'd0));
    issue(nw(32'd1, 32'h23, 0, 0), 4'b0000, 32'd8, 1'b0, 1'b0, "R4 SHL");
    load_ctx(mkop(4'd8, 1'b0, 3'd0));
    issue(nw(32'h80000000, 32'h1F, 0, 0), 4'b0000, 32'd1, 1'b0, 1'b0, "R4 SHR");
    load_ctx(mkop(4'd9, 1'b0, 3'd0));
    issue(nw(32'h80000000, 32'd4, 0, 0), 4'b0000, 32'hF8000000, 1'b0, 1'b0, "R4 SRA");

    // R12 unused op code
    load_ctx(mkop(4'd15, 1'b0, 3'd0));
    issue(nw(32'h55, 32'h66, 0, 0), 4'b0000, 32'd0, 1'b0, 1'b1, "R12 op15");

    // R2 operand sources
    load_ctx(mk(4'd14, 3'd5, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 1'b1, 16'h8001));
    issue(nw(32'h1, 0, 0, 0), 4'b0000, 32'hFFFF8001, 1'b0, 1'b1, "R2 imm");
    load_ctx(mk(4'd3, 3'd3, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'd1, 32'd2, 32'd20, 32'd10), 4'b0000, 32'd30, 1'b0, 1'b0, "R2 west+south");
    load_ctx(mk(4'd3, 3'd0, 3'd7, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'd9, 32'd2, 32'd3, 32'd4), 4'b0000, 32'd9, 1'b0, 1'b0, "R2 zero source");

    // R6 flag steering select
    load_ctx(mkop(4'd4, 1'b0, 3'd0));
    issue(nw(32'd3, 32'd3, 0, 0), 4'b0000, 32'd0, 1'b0, 1'b1, "R6 zero flag");
    load_ctx(mkop(4'd10, 1'b0, 3'd0));
    issue(nw(32'hAAAA, 32'h5555, 0, 0), 4'b0000, 32'hAAAA, 1'b0, 1'b0, "R6 select A");
    issue(nw(32'hAAAA, 32'h5555, 0, 0), 4'b0000, 32'h5555, 1'b0, 1'b0, "R6 select B");
    load_ctx(mk(4'd14, 3'd6, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'h1, 0, 0, 0), 4'b0000, 32'h5555, 1'b0, 1'b0, "R2 previous result");

    // R8 register file write and next-cycle read
    load_ctx(mk(4'd14, 3'd0, 3'd0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd2, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'd5, 0, 0, 0), 4'b0000, 32'd5, 1'b0, 1'b0, "R8 write");
    load_ctx(mk(4'd3, 3'd4, 3'd0, 2'd2, 2'd0, 1'b1, 1'b0, 2'd2, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'd1, 0, 0, 0), 4'b0000, 32'd6, 1'b0, 1'b0, "R8 accumulate 1");
    issue(nw(32'd1, 0, 0, 0), 4'b0000, 32'd7, 1'b0, 1'b0, "R8 accumulate 2");
    issue(nw(32'd1, 0, 0, 0), 4'b0000, 32'd8, 1'b0, 1'b0, "R8 accumulate 3");
    load_ctx(mk(4'd3, 3'd4, 3'd4, 2'd2, 2'd2, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0));
    issue(nw(32'd0, 0, 0, 0), 4'b0000, 32'd16, 1'b0, 1'b0, "R8 both read ports");

    // R1 repeated strobe: last word wins, no acceptance while loading
    @(negedge clk);
    cfg_load_i = 1'b1;
    cfg_word_i = mkop(4'd3, 1'b0, 3'd0);
    @(negedge clk);
    check("R1 ready low during load", {31'd0, in_ready_o}, 32'd0);
    cfg_word_i = mkop(4'd4, 1'b0, 3'd0);
    @(negedge clk);
    cfg_load_i = 1'b0;
    check("R1 ready low at commit", {31'd0, in_ready_o}, 32'd0);
    @(negedge clk);
    check("R1 ready after commit", {31'd0, in_ready_o}, 32'd1);
    issue(nw(32'd10, 32'd4, 0, 0), 4'b0000, 32'd6, 1'b0, 1'b0, "R1 last word wins");

    // R10 store held until grant
    load_ctx(mk(4'd14, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 3'd0, 2'd0, 2'd0, 1'b0, 16'h0042));
    issue(nw(32'hDEADBEEF, 0, 0, 0), 4'b0000, 32'hDEADBEEF, 1'b0, 1'b0, "R10 store result");
    check("R10 req", {31'd0, st_req_o}, 32'd1);
    check("R10 data", st_data_o, 32'hDEADBEEF);
    check("R10 addr", {24'd0, st_addr_o}, 32'h42);
    check("R10 ready low", {31'd0, in_ready_o}, 32'd0);
    repeat (3) @(negedge clk);
    check("R10 req held", {31'd0, st_req_o}, 32'd1);
    check("R10 data held", st_data_o, 32'hDEADBEEF);
    st_gnt_i = 1'b1;
    @(negedge clk);
    st_gnt_i = 1'b0;
    check("R10 req dropped", {31'd0, st_req_o}, 32'd0);
    check("R10 ready back", {31'd0, in_ready_o}, 32'd1);

    repeat (4) @(negedge clk);
    check("R9 all results seen", exp_q.size(), 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule